// File: doc/BRIEF.md
# Priority Interrupt Arbiter with Round-Robin Fairness

This block looks at a vector of pending interrupt requests, each with a programmable 8-bit priority. Every cycle it selects the best candidate and the runner-up. It then asks the processor for a dispatch when the best candidate's priority is strictly above the threshold currently in force. A request becomes a candidate only while its pending bit is high. Requests of equal priority are served in rotating order, so no single source starves the others at the same level.

When the processor takes the offered interrupt (accept strobe), the winner is copied into the active record. Its priority then becomes the working threshold, so only strictly higher requests can raise a new dispatch. When service ends (complete strobe), the active record is dropped and the software threshold input governs again. All outputs are registered: a change on the inputs shows on the outputs one clock later.

Top module: `irq_prio_arb`

## Requirements
- R1: While and right after synchronous reset, dispatch, second_valid, second_fair, active_valid and active_fair are 0, and all id and priority outputs are 0.
- R2: One clock after the inputs settle, win_id and win_prio name the pending source with the highest priority. With no pending source, both read 0.
- R3: dispatch is 1 only when a pending source exists and win_prio is strictly greater than the working threshold. A priority equal to the threshold does not dispatch.
- R4: second_id and second_prio name the best pending source other than the winner. second_valid is 0 when fewer than two sources are pending, and the runner-up fields then read 0.
- R5: Among sources tied at the top priority, the winner is the lowest id above the round-robin pointer, wrapping around to the lowest tied id. After reset the pointer is at the top of the id range, so ties go to the lowest id.
- R6: On an accepted grant, the pointer moves to the granted id only if the runner-up shared the winner's priority. A grant without a tie leaves the rotation order unchanged.
- R7: accept while dispatch is 1 loads active_id and active_prio from win_id and win_prio. It sets active_fair to 1 if the grant resolved a tie. It makes the working threshold equal to active_prio, so equal or lower requests are masked while strictly higher ones still dispatch.
- R8: accept while dispatch is 0 leaves the active record unchanged.
- R9: complete (without a same-cycle effective accept) clears active_valid, and the working threshold returns to the thresh input.
- R10: second_fair is 1 exactly when a runner-up exists with the same priority as the winner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pend | input | NSRC | Pending request per source |
| prio_flat | input | NSRC*8 | Priority per source, source i at bits [8i+7:8i] |
| thresh | input | 8 | Software priority threshold |
| accept | input | 1 | Processor takes the offered interrupt |
| complete | input | 1 | Service of the active interrupt finished |
| dispatch | output | 1 | Dispatch request |
| win_id | output | 8 | Winning source id |
| win_prio | output | 8 | Winning priority |
| second_valid | output | 1 | A runner-up exists |
| second_id | output | 8 | Runner-up id |
| second_prio | output | 8 | Runner-up priority |
| second_fair | output | 1 | Runner-up ties the winner's priority |
| active_valid | output | 1 | An interrupt is in service |
| active_id | output | 8 | Id in service |
| active_prio | output | 8 | Priority in service |
| active_fair | output | 1 | The grant in service resolved a tie |

## Verification
The selection logic is tried with several pending patterns:
- An empty vector and a single request show the no-candidate and no-runner-up cases.
- Distinct priorities show that ordering follows priority, not id.
- A threshold equal to the winner separates a strict from a non-strict compare.
- Priority-zero requests with a zero threshold confirm that a pending request alone does not dispatch.
- A full vector with high priorities on both end ids checks the range edges.
- Equal-priority groups show the id tie-break after reset.

Directed sequences then grant tied and untied winners. They show that the rotation advances only after a tied grant, that the active priority masks its own level but not a higher one, and that completion hands control back to the software threshold.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int ID_W  = 8;
  localparam int PRI_W = 8;

  typedef struct packed {
    logic             valid;
    logic [PRI_W-1:0] prio;
    logic [ID_W-1:0]  id;
  } cand_t;
endpackage

// File: rtl/irq_prio_scan.sv
// Combinational ranking of pending sources: best and runner-up.
// Rank key = {priority, above-pointer flag, inverted id}; larger wins.
module irq_prio_scan
  import irq_arb_pkg::*;
#(
  parameter int NSRC = 32
) (
  input  logic [NSRC-1:0]       pend,
  input  logic [NSRC*PRI_W-1:0] prio_flat,
  input  logic [ID_W-1:0]       rr_ptr,
  output cand_t                 best,
  output cand_t                 second
);
  localparam int KW = PRI_W + 1 + ID_W;

  logic          b_v, s_v;
  logic [KW-1:0] b_k, s_k, k;

  always_comb begin
    b_v = 1'b0;
    s_v = 1'b0;
    b_k = '0;
    s_k = '0;
    k   = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (pend[i]) begin
        k = {prio_flat[i*PRI_W +: PRI_W], (ID_W'(i) > rr_ptr), ~ID_W'(i)};
        if (!b_v || k > b_k) begin
          s_v = b_v;
          s_k = b_k;
          b_v = 1'b1;
          b_k = k;
        end else if (!s_v || k > s_k) begin
          s_v = 1'b1;
          s_k = k;
        end
      end
    end
  end

  always_comb begin
    best.valid   = b_v;
    best.prio    = b_v ? b_k[KW-1 -: PRI_W] : '0;
    best.id      = b_v ? ~b_k[ID_W-1:0] : '0;
    second.valid = s_v;
    second.prio  = s_v ? s_k[KW-1 -: PRI_W] : '0;
    second.id    = s_v ? ~s_k[ID_W-1:0] : '0;
  end
endmodule

// File: rtl/irq_active_track.sv
// Active record and round-robin pointer; exposes next-state for the
// threshold so the registered dispatch agrees with the new record.
module irq_active_track
  import irq_arb_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic             complete,
  input  logic [ID_W-1:0]  grant_id,
  input  logic [PRI_W-1:0] grant_prio,
  input  logic             grant_tie,
  output logic             act_valid,
  output logic [ID_W-1:0]  act_id,
  output logic [PRI_W-1:0] act_prio,
  output logic             act_fair,
  output logic             nxt_valid,
  output logic [PRI_W-1:0] nxt_prio,
  output logic [ID_W-1:0]  rr_ptr
);
  logic [ID_W-1:0] nxt_id, nxt_rr;
  logic            nxt_fair;

  always_comb begin
    nxt_valid = act_valid;
    nxt_prio  = act_prio;
    nxt_id    = act_id;
    nxt_fair  = act_fair;
    nxt_rr    = rr_ptr;
    if (take) begin
      nxt_valid = 1'b1;
      nxt_prio  = grant_prio;
      nxt_id    = grant_id;
      nxt_fair  = grant_tie;
      if (grant_tie) nxt_rr = grant_id;
    end else if (complete) begin
      nxt_valid = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_valid <= 1'b0;
      act_id    <= '0;
      act_prio  <= '0;
      act_fair  <= 1'b0;
      rr_ptr    <= '1;
    end else begin
      act_valid <= nxt_valid;
      act_id    <= nxt_id;
      act_prio  <= nxt_prio;
      act_fair  <= nxt_fair;
      rr_ptr    <= nxt_rr;
    end
  end
endmodule

// File: rtl/irq_prio_arb.sv
// Top: scan, registered result, active tracking. NSRC must not exceed 2**ID_W.
module irq_prio_arb
  import irq_arb_pkg::*;
#(
  parameter int NSRC = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NSRC-1:0]       pend,
  input  logic [NSRC*PRI_W-1:0] prio_flat,
  input  logic [PRI_W-1:0]      thresh,
  input  logic                  accept,
  input  logic                  complete,
  output logic                  dispatch,
  output logic [ID_W-1:0]       win_id,
  output logic [PRI_W-1:0]      win_prio,
  output logic                  second_valid,
  output logic [ID_W-1:0]       second_id,
  output logic [PRI_W-1:0]      second_prio,
  output logic                  second_fair,
  output logic                  active_valid,
  output logic [ID_W-1:0]       active_id,
  output logic [PRI_W-1:0]      active_prio,
  output logic                  active_fair
);
  cand_t            best, runner, win_q, sec_q;
  logic             disp_q, tie_q;
  logic [ID_W-1:0]  rr_ptr;
  logic             nxt_valid;
  logic [PRI_W-1:0] nxt_prio, eff_thr;

  irq_prio_scan #(.NSRC(NSRC)) u_scan (
    .pend      (pend),
    .prio_flat (prio_flat),
    .rr_ptr    (rr_ptr),
    .best      (best),
    .second    (runner)
  );

  irq_active_track u_act (
    .clk        (clk),
    .rst        (rst),
    .take       (accept && disp_q),
    .complete   (complete),
    .grant_id   (win_q.id),
    .grant_prio (win_q.prio),
    .grant_tie  (tie_q),
    .act_valid  (active_valid),
    .act_id     (active_id),
    .act_prio   (active_prio),
    .act_fair   (active_fair),
    .nxt_valid  (nxt_valid),
    .nxt_prio   (nxt_prio),
    .rr_ptr     (rr_ptr)
  );

  assign eff_thr = nxt_valid ? nxt_prio : thresh;

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q  <= '0;
      sec_q  <= '0;
      disp_q <= 1'b0;
      tie_q  <= 1'b0;
    end else begin
      win_q  <= best;
      sec_q  <= runner;
      disp_q <= best.valid && (best.prio > eff_thr);
      tie_q  <= runner.valid && (runner.prio == best.prio);
    end
  end

  assign dispatch     = disp_q;
  assign win_id       = win_q.id;
  assign win_prio     = win_q.prio;
  assign second_valid = sec_q.valid;
  assign second_id    = sec_q.id;
  assign second_prio  = sec_q.prio;
  assign second_fair  = tie_q;
endmodule

// File: rtl/irq_prio_arb_chk.sv
module irq_prio_arb_chk
  import irq_arb_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic [PRI_W-1:0] thresh,
  input logic             accept,
  input logic             complete,
  input logic             dispatch,
  input logic [ID_W-1:0]  win_id,
  input logic [PRI_W-1:0] win_prio,
  input logic             second_valid,
  input logic [ID_W-1:0]  second_id,
  input logic [PRI_W-1:0] second_prio,
  input logic             second_fair,
  input logic             active_valid,
  input logic [ID_W-1:0]  active_id,
  input logic [PRI_W-1:0] active_prio
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!dispatch && !active_valid && !second_valid));

  a_r3_strict_above: assert property (@(posedge clk) disable iff (rst)
    dispatch |-> (win_prio > (active_valid ? active_prio : $past(thresh))));

  a_r4_runner_below: assert property (@(posedge clk) disable iff (rst)
    second_valid |-> (second_prio <= win_prio && second_id != win_id));

  a_r7_grant_loads: assert property (@(posedge clk) disable iff (rst)
    (dispatch && accept) |=> (active_valid && active_id == $past(win_id)
                              && active_prio == $past(win_prio)));

  a_r8_idle_accept: assert property (@(posedge clk) disable iff (rst)
    (!dispatch && accept && !complete) |=>
      ($stable(active_valid) && $stable(active_id) && $stable(active_prio)));

  a_r9_complete_clears: assert property (@(posedge clk) disable iff (rst)
    (complete && !(accept && dispatch)) |=> !active_valid);

  a_r10_fair_tie: assert property (@(posedge clk) disable iff (rst)
    second_fair |-> (second_valid && second_prio == win_prio));
endmodule

bind irq_prio_arb irq_prio_arb_chk u_chk (.*);

// File: tb/irq_prio_arb_test.sv
`timescale 1ns/1ps
module irq_prio_arb_test;
  localparam int N = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] pend = '0;
  logic [7:0]   prio_arr [N];
  logic [N*8-1:0] prio_flat;
  logic [7:0]   thresh = '0;
  logic         accept = 1'b0, complete = 1'b0;
  logic         dispatch, second_valid, second_fair, active_valid, active_fair;
  logic [7:0]   win_id, win_prio, second_id, second_prio, active_id, active_prio;

  int total = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  always_comb
    for (int i = 0; i < N; i++) prio_flat[i*8 +: 8] = prio_arr[i];

  irq_prio_arb #(.NSRC(N)) uut (.*);

  typedef struct packed {
    logic [31:0] pend;
    logic [7:0]  ida, pra, idb, prb, pdef, thr;
    logic        ed;
    logic [7:0]  ew, ewp;
    logic        es;
    logic [7:0]  esi, esp;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{32'h0,        8'd0,  8'd0,   8'd0, 8'd0,   8'd0, 8'd0,   1'b0, 8'd0,  8'd0,   1'b0, 8'd0,  8'd0},
    '{32'h20,       8'd5,  8'd9,   8'd0, 8'd0,   8'd3, 8'd4,   1'b1, 8'd5,  8'd9,   1'b0, 8'd0,  8'd0},
    '{32'h0010_0084,8'd7,  8'd10,  8'd20,8'd6,   8'd4, 8'd2,   1'b1, 8'd7,  8'd10,  1'b1, 8'd20, 8'd6},
    '{32'h0010_0084,8'd7,  8'd10,  8'd20,8'd6,   8'd4, 8'd10,  1'b0, 8'd7,  8'd10,  1'b1, 8'd20, 8'd6},
    '{32'h1208,     8'd30, 8'd1,   8'd31,8'd1,   8'd5, 8'd0,   1'b1, 8'd3,  8'd5,   1'b1, 8'd9,  8'd5},
    '{32'hFFFF_FFFF,8'd31, 8'd200, 8'd0, 8'd199, 8'd1, 8'd199, 1'b1, 8'd31, 8'd200, 1'b1, 8'd0,  8'd199},
    '{32'h6,        8'd1,  8'd0,   8'd2, 8'd0,   8'd0, 8'd0,   1'b0, 8'd1,  8'd0,   1'b1, 8'd2,  8'd0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic set_prio(input logic [7:0] def, input logic [7:0] ia, input logic [7:0] pa,
                          input logic [7:0] ib, input logic [7:0] pb);
    for (int i = 0; i < N; i++) prio_arr[i] = def;
    prio_arr[ia] = pa;
    prio_arr[ib] = pb;
  endtask

  task automatic pulse_accept();
    accept = 1'b1; tick(); accept = 1'b0;
  endtask

  task automatic pulse_complete();
    complete = 1'b1; tick(); complete = 1'b0;
  endtask

  initial begin
    set_prio(8'd0, 8'd0, 8'd0, 8'd0, 8'd0);
    tick(); tick();
    // R1: state during reset
    chk("R1 dispatch", dispatch, 0);
    chk("R1 active_valid", active_valid, 0);
    chk("R1 second_valid", second_valid, 0);
    chk("R1 win_id", win_id, 0);
    rst = 1'b0;

    // Table walk: R2 R3 R4 R5 R10
    for (int v = 0; v < 7; v++) begin
      pend   = VECS[v].pend;
      thresh = VECS[v].thr;
      set_prio(VECS[v].pdef, VECS[v].ida, VECS[v].pra, VECS[v].idb, VECS[v].prb);
      tick();
      chk($sformatf("R3 v%0d dispatch", v), dispatch, VECS[v].ed);
      chk($sformatf("R2 v%0d win_id", v), win_id, VECS[v].ew);
      chk($sformatf("R2 v%0d win_prio", v), win_prio, VECS[v].ewp);
      chk($sformatf("R4 v%0d second_valid", v), second_valid, VECS[v].es);
      chk($sformatf("R4 v%0d second_id", v), second_id, VECS[v].esi);
      chk($sformatf("R4 v%0d second_prio", v), second_prio, VECS[v].esp);
      chk($sformatf("R10 v%0d second_fair", v), second_fair,
          VECS[v].es && (VECS[v].esp == VECS[v].ewp));
    end

    // Rotation among ids 3, 9, 12 at priority 5
    pend = 32'h1208; thresh = 8'd0;
    set_prio(8'd5, 8'd0, 8'd5, 8'd0, 8'd5);
    tick(); tick();
    chk("R5 first tie winner", win_id, 3);
    pulse_accept();
    chk("R7 active_id", active_id, 3);
    chk("R7 active_fair tie", active_fair, 1);
    chk("R7 equal prio masked", dispatch, 0);
    tick();
    chk("R6 rotated winner", win_id, 9);
    chk("R6 rotated second", second_id, 12);
    pulse_accept();
    chk("R8 idle accept ignored", active_id, 3);
    chk("R8 idle accept valid", active_valid, 1);
    pulse_complete();
    chk("R9 complete clears", active_valid, 0);
    chk("R9 threshold restored", dispatch, 1);
    pulse_accept();
    chk("R7 second grant id", active_id, 9);
    tick();
    chk("R5 wrap order next", win_id, 12);
    pulse_complete();

    // Untied grant must not move the pointer
    pend = 32'h1008;
    prio_arr[12] = 8'd6;
    tick();
    chk("R2 untied winner", win_id, 12);
    chk("R10 no tie", second_fair, 0);
    pulse_accept();
    chk("R7 untied fair", active_fair, 0);
    pulse_complete();
    pend = 32'h1208;
    prio_arr[12] = 8'd5;
    tick(); tick();
    chk("R6 pointer held", win_id, 12);

    // Preemption by a strictly higher request
    pulse_accept();
    chk("R7 active before preempt", active_id, 12);
    pend[20] = 1'b1;
    prio_arr[20] = 8'd8;
    tick();
    chk("R7 higher still dispatches", dispatch, 1);
    chk("R7 higher winner", win_id, 20);
    pulse_accept();
    chk("R7 preempt active", active_prio, 8);
    pulse_complete();

    // Threshold input governs after completion
    pend = 32'h1208;
    thresh = 8'd7;
    tick();
    chk("R9 thresh masks", dispatch, 0);
    thresh = 8'd4;
    tick();
    chk("R3 thresh below", dispatch, 1);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule